// File: doc/BRIEF.md
# Direct-Mapped Cache Tag Checker

This block holds the tag and valid state of a direct-mapped external cache and decides, for every physical address, whether that address may use the cache at all. A controller presents an address with a lookup strobe and receives, one clock later, a registered hit flag, a cacheable flag and the line index that addresses the data array. A fill strobe on the same address port allocates the line, which means it writes the tag and sets the valid bit.

The cache size and the number of tag bits in use are run-time settings. Together with the line offset they fix the highest address whose tag can be stored without loss. An address with any bit set at or above that limit would share a line with a lower address that differs from it only in that bit. The block therefore treats such addresses as non-cacheable. The same applies to addresses at or above a programmable non-cacheable base and to every access while the global enable is low. A non-cacheable address never hits and is never allocated.

Top module: `dm_tag_check`

## Requirements
- R1: A synchronous active-low reset clears every valid bit and drives res_valid, res_hit, res_cacheable and res_index to zero, so no lookup hits until a fill has been made.
- R2: The index is the address field that starts at bit OFF_W (default 4) and is IDX_MIN_W + cfg_size bits wide (default 3 + cfg_size, clamped to IDX_MAX_W = 6). It is reported on res_index in the cycle after the lookup strobe.
- R3: After a fill of a cacheable address, a lookup of any address in the same line (same index and tag, any offset) reports a hit.
- R4: An address with a set bit at position OFF_W + index width + tag bits or above is reported non-cacheable, and a fill of it leaves the tag store unchanged.
- R5: The lowest and the highest address in the address space that share an index never both report a hit.
- R6: When cfg_nc_en is high, an address at or above cfg_nc_base is non-cacheable and is not allocated by a fill. Addresses below the base are not affected.
- R7: When cfg_enable is low, every lookup reports miss and non-cacheable, and fills allocate nothing.
- R8: A fill of a different tag at an occupied index replaces the old line, and the old address then misses.
- R9: When a lookup and a fill fall in the same cycle, the lookup reports the state before the fill, and the fill takes effect for the next lookup.
- R10: res_valid is high exactly in the cycle after a lookup strobe. In all other cycles res_hit and res_cacheable are low, and a hit is always cacheable.
- R11: Lowering cfg_tag_bits lowers the covered limit. With a 6-bit index, 7 tag bits cover addresses below 2^17, and 8 tag bits cover addresses below 2^18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Physical address for a lookup or a fill |
| lk_stb | input | 1 | Lookup request |
| fill_stb | input | 1 | Allocate the line of addr if it is cacheable |
| cfg_enable | input | 1 | Global cache enable |
| cfg_size | input | SIZE_W | Cache size code, index width = IDX_MIN_W + code |
| cfg_tag_bits | input | TBITS_W | Number of tag bits compared, clamped to TAG_MAX_W |
| cfg_nc_en | input | 1 | Enables the non-cacheable region |
| cfg_nc_base | input | ADDR_W | Lowest address of the non-cacheable region |
| res_valid | output | 1 | Result of the previous cycle's lookup is present |
| res_hit | output | 1 | Lookup hit |
| res_cacheable | output | 1 | Looked-up address is cacheable |
| res_index | output | IDX_MAX_W | Line index for the data array |

## Verification
A lookup and a fill can fall in the same cycle on the shared address port. In that case the lookup must see the tag store as it was before the edge on which the fill writes. The bench raises both strobes together on a fresh line and expects a miss. It then expects a hit from a lookup in the following cycle. The same question of ordering arises for a fill of an uncovered address that aliases an occupied line. The bench judges it by looking up the low alias afterwards, which must report the state the fill was not allowed to change.

// File: rtl/dmtc_pkg.sv
// Package dmtc_pkg
// Default geometry shared by the tag checker and its sub-blocks.
// Assumes byte addresses and a power-of-two line size.
package dmtc_pkg;
    localparam int unsigned DEF_ADDR_W    = 20;
    localparam int unsigned DEF_OFF_W     = 4;
    localparam int unsigned DEF_IDX_MIN_W = 3;
    localparam int unsigned DEF_IDX_MAX_W = 6;
    localparam int unsigned DEF_TAG_MAX_W = 8;
endpackage

// File: rtl/dmtc_decode.sv
// Module dmtc_decode
// Splits an address into index and tag for the current size and tag-bit
// settings. Also decides whether the address is cacheable: it must be
// below the tag-covered limit, outside the non-cacheable region, and the
// cache must be enabled. Purely combinational.
module dmtc_decode #(
    parameter int unsigned ADDR_W    = dmtc_pkg::DEF_ADDR_W,
    parameter int unsigned OFF_W     = dmtc_pkg::DEF_OFF_W,
    parameter int unsigned IDX_MIN_W = dmtc_pkg::DEF_IDX_MIN_W,
    parameter int unsigned IDX_MAX_W = dmtc_pkg::DEF_IDX_MAX_W,
    parameter int unsigned TAG_MAX_W = dmtc_pkg::DEF_TAG_MAX_W,
    parameter int unsigned SIZE_W    = 2,
    parameter int unsigned TBITS_W   = 4
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 cfg_enable,
    input  logic [SIZE_W-1:0]    cfg_size,
    input  logic [TBITS_W-1:0]   cfg_tag_bits,
    input  logic                 cfg_nc_en,
    input  logic [ADDR_W-1:0]    cfg_nc_base,
    output logic [IDX_MAX_W-1:0] index,
    output logic [TAG_MAX_W-1:0] tag,
    output logic                 cacheable
);
    int unsigned idx_w;
    int unsigned tag_w;
    int unsigned limit;
    logic        covered;
    logic        in_region;

    // Resolve the effective widths and the covered limit.
    always_comb begin
        idx_w = IDX_MIN_W + int'(cfg_size);
        if (idx_w > IDX_MAX_W) idx_w = IDX_MAX_W;
        tag_w = int'(cfg_tag_bits);
        if (tag_w > TAG_MAX_W) tag_w = TAG_MAX_W;
        limit = OFF_W + idx_w + tag_w;
    end

    // Extract the fields and classify the address.
    always_comb begin
        index = IDX_MAX_W'((addr >> OFF_W) &
                           ((ADDR_W'(1) << idx_w) - ADDR_W'(1)));
        tag   = TAG_MAX_W'((addr >> (OFF_W + idx_w)) &
                           ((ADDR_W'(1) << tag_w) - ADDR_W'(1)));
        covered   = (limit >= ADDR_W) ? 1'b1 : ((addr >> limit) == '0);
        in_region = cfg_nc_en && (addr >= cfg_nc_base);
        cacheable = cfg_enable && covered && !in_region;
    end
endmodule

// File: rtl/dmtc_store.sv
// Module dmtc_store
// Tag and valid storage, one entry per line, with an asynchronous read
// and a synchronous write. Reset clears every entry. A read in the same
// cycle as a write returns the old contents.
module dmtc_store #(
    parameter int unsigned IDX_W = dmtc_pkg::DEF_IDX_MAX_W,
    parameter int unsigned TAG_W = dmtc_pkg::DEF_TAG_MAX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    localparam int unsigned LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Hold one line: clear on reset, load on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                tag_q[g]   <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                valid_q[g] <= 1'b1;
                tag_q[g]   <= wr_tag;
            end
        end
    end

    // Read port.
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
    end
endmodule

// File: rtl/dm_tag_check.sv
// Module dm_tag_check
// Tag checker for a direct-mapped external cache. A lookup returns the
// hit, cacheable and index results one cycle after its strobe. A fill
// allocates the line only when the address is cacheable. Assumes that
// the size and tag-bit settings change only while the store is empty,
// for example directly after reset.
module dm_tag_check #(
    parameter int unsigned ADDR_W    = dmtc_pkg::DEF_ADDR_W,
    parameter int unsigned OFF_W     = dmtc_pkg::DEF_OFF_W,
    parameter int unsigned IDX_MIN_W = dmtc_pkg::DEF_IDX_MIN_W,
    parameter int unsigned IDX_MAX_W = dmtc_pkg::DEF_IDX_MAX_W,
    parameter int unsigned TAG_MAX_W = dmtc_pkg::DEF_TAG_MAX_W,
    localparam int unsigned SIZE_W   = $clog2(IDX_MAX_W - IDX_MIN_W + 1),
    localparam int unsigned TBITS_W  = $clog2(TAG_MAX_W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 lk_stb,
    input  logic                 fill_stb,
    input  logic                 cfg_enable,
    input  logic [SIZE_W-1:0]    cfg_size,
    input  logic [TBITS_W-1:0]   cfg_tag_bits,
    input  logic                 cfg_nc_en,
    input  logic [ADDR_W-1:0]    cfg_nc_base,
    output logic                 res_valid,
    output logic                 res_hit,
    output logic                 res_cacheable,
    output logic [IDX_MAX_W-1:0] res_index
);
    logic [IDX_MAX_W-1:0] cur_index;
    logic [TAG_MAX_W-1:0] cur_tag;
    logic                 cur_cacheable;
    logic                 line_valid;
    logic [TAG_MAX_W-1:0] line_tag;
    logic                 hit_now;

    dmtc_decode #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_MIN_W(IDX_MIN_W),
        .IDX_MAX_W(IDX_MAX_W), .TAG_MAX_W(TAG_MAX_W),
        .SIZE_W(SIZE_W), .TBITS_W(TBITS_W)
    ) u_decode (
        .addr(addr), .cfg_enable(cfg_enable), .cfg_size(cfg_size),
        .cfg_tag_bits(cfg_tag_bits), .cfg_nc_en(cfg_nc_en),
        .cfg_nc_base(cfg_nc_base), .index(cur_index), .tag(cur_tag),
        .cacheable(cur_cacheable)
    );

    dmtc_store #(.IDX_W(IDX_MAX_W), .TAG_W(TAG_MAX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_idx(cur_index),
        .rd_valid(line_valid), .rd_tag(line_tag),
        .wr_en(fill_stb && cur_cacheable), .wr_idx(cur_index),
        .wr_tag(cur_tag)
    );

    // A hit needs a valid line, an equal tag and a cacheable address.
    always_comb hit_now = line_valid && (line_tag == cur_tag) && cur_cacheable;

    // Register the lookup result; outputs stay zero between lookups.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid     <= 1'b0;
            res_hit       <= 1'b0;
            res_cacheable <= 1'b0;
            res_index     <= '0;
        end else begin
            res_valid     <= lk_stb;
            res_hit       <= lk_stb && hit_now;
            res_cacheable <= lk_stb && cur_cacheable;
            res_index     <= lk_stb ? cur_index : '0;
        end
    end
endmodule

// File: rtl/dmtc_checker.sv
// Module dmtc_checker
// Protocol properties of dm_tag_check, observed at its ports only.
module dmtc_checker #(
    parameter int unsigned ADDR_W    = dmtc_pkg::DEF_ADDR_W,
    parameter int unsigned OFF_W     = dmtc_pkg::DEF_OFF_W,
    parameter int unsigned IDX_MIN_W = dmtc_pkg::DEF_IDX_MIN_W,
    parameter int unsigned IDX_MAX_W = dmtc_pkg::DEF_IDX_MAX_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    addr,
    input logic                 lk_stb,
    input logic                 cfg_enable,
    input logic                 cfg_nc_en,
    input logic [ADDR_W-1:0]    cfg_nc_base,
    input logic                 res_valid,
    input logic                 res_hit,
    input logic                 res_cacheable,
    input logic [IDX_MAX_W-1:0] res_index
);
    a_r10_hit_is_cacheable: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> (res_cacheable && res_valid));

    a_r10_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        lk_stb |=> res_valid);

    a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_stb |=> (!res_valid && !res_hit && !res_cacheable));

    a_r7_disabled_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_stb && !cfg_enable) |=> (!res_hit && !res_cacheable));

    a_r6_region_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_stb && cfg_nc_en && (addr >= cfg_nc_base)) |=> !res_cacheable);

    a_r2_low_index_bits: assert property (@(posedge clk) disable iff (!rst_n)
        lk_stb |=> (res_index[IDX_MIN_W-1:0] == $past(addr[OFF_W +: IDX_MIN_W])));
endmodule

bind dm_tag_check dmtc_checker #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_MIN_W(IDX_MIN_W), .IDX_MAX_W(IDX_MAX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .lk_stb(lk_stb),
    .cfg_enable(cfg_enable), .cfg_nc_en(cfg_nc_en), .cfg_nc_base(cfg_nc_base),
    .res_valid(res_valid), .res_hit(res_hit), .res_cacheable(res_cacheable),
    .res_index(res_index)
);

// File: tb/dm_tag_check_test.sv
module dm_tag_check_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] addr = '0;
    logic        lk_stb = 1'b0;
    logic        fill_stb = 1'b0;
    logic        cfg_enable = 1'b1;
    logic [1:0]  cfg_size = 2'd0;
    logic [3:0]  cfg_tag_bits = 4'd8;
    logic        cfg_nc_en = 1'b0;
    logic [19:0] cfg_nc_base = '0;
    logic        res_valid, res_hit, res_cacheable;
    logic [5:0]  res_index;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dm_tag_check uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .lk_stb(lk_stb),
        .fill_stb(fill_stb), .cfg_enable(cfg_enable), .cfg_size(cfg_size),
        .cfg_tag_bits(cfg_tag_bits), .cfg_nc_en(cfg_nc_en),
        .cfg_nc_base(cfg_nc_base), .res_valid(res_valid), .res_hit(res_hit),
        .res_cacheable(res_cacheable), .res_index(res_index)
    );

    // Vector: [27:24] requirement, [23:22] op (0 lookup, 1 fill),
    // [21:2] address, [1] expected hit, [0] expected cacheable.
    // Setting: 3-bit index, 8 tag bits, covered limit 0x8000.
    localparam logic [27:0] VEC [15] = '{
        {4'd1,  2'd0, 20'h00010, 2'b01},  // R1 cold miss
        {4'd3,  2'd1, 20'h00010, 2'b00},
        {4'd3,  2'd0, 20'h00010, 2'b11},  // R3 hit
        {4'd3,  2'd0, 20'h0001C, 2'b11},  // R3 other offset, same line
        {4'd8,  2'd0, 20'h00090, 2'b01},  // R8 other tag, same index
        {4'd8,  2'd1, 20'h00090, 2'b00},
        {4'd8,  2'd0, 20'h00090, 2'b11},
        {4'd8,  2'd0, 20'h00010, 2'b01},  // R8 replaced line misses
        {4'd4,  2'd0, 20'h08010, 2'b00},  // R4 above limit
        {4'd4,  2'd1, 20'h08010, 2'b00},  // R4 fill must be ignored
        {4'd4,  2'd0, 20'h00090, 2'b11},
        {4'd4,  2'd0, 20'h00010, 2'b01},  // R4 alias not allocated
        {4'd3,  2'd0, 20'h07FF0, 2'b01},  // R3 highest covered line
        {4'd3,  2'd1, 20'h07FF0, 2'b00},
        {4'd3,  2'd0, 20'h07FF0, 2'b11}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle of strobes; results are sampled on return.
    task automatic step(input logic lk, input logic fl, input logic [19:0] a);
        addr = a; lk_stb = lk; fill_stb = fl;
        @(negedge clk);
        lk_stb = 1'b0; fill_stb = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic h_low, h_high;
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 res_valid", res_valid, 0);
        chk("R1 res_hit", res_hit, 0);
        chk("R1 res_index", res_index, 0);

        for (int i = 0; i < 15; i++) begin
            step(VEC[i][22] == 1'b0, VEC[i][22], VEC[i][21:2]);
            if (VEC[i][22] == 1'b0) begin
                chk($sformatf("R%0d table[%0d] hit", VEC[i][27:24], i), res_hit, VEC[i][1]);
                chk($sformatf("R%0d table[%0d] cacheable", VEC[i][27:24], i),
                    res_cacheable, VEC[i][0]);
                chk($sformatf("R2 table[%0d] index", i), res_index, (VEC[i][21:2] >> 4) & 7);
                chk($sformatf("R10 table[%0d] valid", i), res_valid, 1);
            end
        end

        // R10: no strobe, no result
        step(1'b0, 1'b0, 20'h00010);
        chk("R10 idle valid", res_valid, 0);
        chk("R10 idle hit", res_hit, 0);

        // R5: lowest and highest address sharing index 1
        do_reset();
        step(1'b0, 1'b1, 20'h00010);
        step(1'b0, 1'b1, 20'hFFF9F);
        step(1'b1, 1'b0, 20'h00010); h_low = res_hit;
        step(1'b1, 1'b0, 20'hFFF9F); h_high = res_hit;
        chk("R5 not both hit", h_low && h_high, 0);
        chk("R5 low alias kept", h_low, 1);
        chk("R5 high alias cacheable", res_cacheable, 0);

        // R6: non-cacheable region at 0x04000
        cfg_nc_en = 1'b1; cfg_nc_base = 20'h04000;
        step(1'b1, 1'b0, 20'h04000);
        chk("R6 base bypass", res_cacheable, 0);
        step(1'b1, 1'b0, 20'h03FF0);
        chk("R6 below base cacheable", res_cacheable, 1);
        step(1'b0, 1'b1, 20'h04000);
        cfg_nc_en = 1'b0;
        step(1'b1, 1'b0, 20'h04000);
        chk("R6 region fill not allocated", res_hit, 0);
        chk("R6 cacheable after region off", res_cacheable, 1);

        // R7: global disable
        step(1'b0, 1'b1, 20'h07FF0);
        cfg_enable = 1'b0;
        step(1'b1, 1'b0, 20'h07FF0);
        chk("R7 disabled miss", res_hit, 0);
        chk("R7 disabled non-cacheable", res_cacheable, 0);
        step(1'b0, 1'b1, 20'h00100);
        cfg_enable = 1'b1;
        step(1'b1, 1'b0, 20'h00100);
        chk("R7 disabled fill not allocated", res_hit, 0);
        step(1'b1, 1'b0, 20'h07FF0);
        chk("R7 line kept across disable", res_hit, 1);

        // R9: lookup and fill in the same cycle
        step(1'b1, 1'b1, 20'h00200);
        chk("R9 same-cycle lookup sees old state", res_hit, 0);
        step(1'b1, 1'b0, 20'h00200);
        chk("R9 fill visible next lookup", res_hit, 1);

        // R1: reset mid-run clears lines
        do_reset();
        step(1'b1, 1'b0, 20'h00200);
        chk("R1 reset clears valid", res_hit, 0);

        // R11 and R2: 6-bit index, tag bits 7 then 8
        cfg_size = 2'd3; cfg_tag_bits = 4'd7;
        do_reset();
        step(1'b1, 1'b0, 20'h20000);
        chk("R11 7 tag bits, 0x20000 uncovered", res_cacheable, 0);
        step(1'b1, 1'b0, 20'h1FFF0);
        chk("R11 7 tag bits, 0x1FFF0 covered", res_cacheable, 1);
        cfg_tag_bits = 4'd8;
        step(1'b1, 1'b0, 20'h20000);
        chk("R11 8 tag bits, 0x20000 covered", res_cacheable, 1);
        step(1'b1, 1'b0, 20'h40000);
        chk("R11 8 tag bits, 0x40000 uncovered", res_cacheable, 0);
        step(1'b1, 1'b0, 20'h003F0);
        chk("R2 6-bit index", res_index, 6'h3F);

        finish_run();
    end
endmodule